// File: doc/BRIEF.md
# Memory Cycle Sequencer for DRAM or Pseudo-Static RAM

This block turns a held memory request into the control strobes of a 16-bit system memory array. A static mode input picks the array type. It can be four DRAM banks with a row/column multiplexed address, or a word-wide pseudo-static RAM array. In the pseudo-static mode the same output pins carry chip selects, enables and upper address bits instead of row and column strobes. The block also runs DRAM refresh cycles. It drives the data direction line for the memory transceiver and a refresh indicator.

A requester presents address, byte enables, write flag, DMA flag and ROM flag with `req_valid`. It holds them until `done` pulses in the last cycle of the access. `ref_req` asks for a refresh cycle. The block runs on the memory timing clock. `RAS_CLKS` sets the length of every access and refresh in clocks. `COL_DLY` sets how many of those clocks present the row address before the column phase starts.

Top module: `memseq_top`

## Requirements
- R1: While `rst_n` is low and after its release, no cycle runs. All RAS, high-CAS and low-CAS lines are high, `mref_n` is high in DRAM mode, and `mdir` and `done` are low. The latched address is zero, so `ma` is zero.
- R2: A DRAM access (`dram_mode`=1) starts on the clock edge that sees `req_valid` while idle. It lasts `RAS_CLKS` clocks. The first `COL_DLY` clocks put the row address on `ma` with RAS low. The remaining clocks put the column address on `ma` and may assert CAS. `done` is high only in the last clock.
- R3: With 1M devices (`big_dev`=1), the bank is addr[22:21], the row is addr[20:11] and the column is addr[10:1]. During an access exactly the RAS pair of that bank is low: lines 2b and 2b+1 for bank b.
- R4: With 256K devices (`big_dev`=0), the bank is addr[20:19], the row is addr[18:10] and the column is addr[9:1]. `ma[9]` stays zero.
- R5: In the column phase, `cash_n[b]` is low when byte enable bit 1 (odd byte, data 15..8) is set. `casl_n[b]` is low when byte enable bit 0 (even byte, data 7..0) is set. b is the selected bank. No other CAS line is low.
- R6: A DRAM refresh cycle lasts `RAS_CLKS` clocks. During it, all eight RAS lines and `mref_n` are low and every CAS line is high. `done` does not pulse.
- R7: If a refresh request and a memory request are seen in the same idle clock, the refresh runs first. The memory access begins on the clock right after the refresh ends.
- R8: In pseudo-static mode (`dram_mode`=0), `ma` carries addr[11:2] and `ras_n[3:0]` carries addr[15:12]. `ras_n[7:4]` carries an extended-region code: 1111 when addr[23:20] is zero (no extended device), otherwise addr[23:20] minus one.
- R9: In pseudo-static mode, during an access in the lowest megabyte, exactly one of `cash_n` is low, with index {addr[19], addr[1]}. For addresses above the lowest megabyte, none is low.
- R10: In pseudo-static mode, during an access the four low-CAS lines act as enables. `casl_n[2]` is the timing strobe and is low for the whole access. `casl_n[3]` is the read enable and is low on reads. `casl_n[1]` and `casl_n[0]` are the odd- and even-byte write enables, low on writes with byte enable bit 1 or bit 0 set.
- R11: In pseudo-static mode, `mref_n` is low at all times. `ref_req` is ignored: no refresh cycle runs and the outputs stay idle.
- R12: `mdir` is high only during an access that is a read, or a non-DMA ROM access; otherwise it is low.
- R13: A ROM access (`req_rom`=1) runs the full timing and `done` but asserts no RAS, CAS, chip select or enable line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory timing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dram_mode | input | 1 | 1 = DRAM banks, 0 = pseudo-static RAM (static) |
| big_dev | input | 1 | 1 = 1M DRAM devices, 0 = 256K devices (static) |
| req_valid | input | 1 | Memory request present, held until `done` |
| req_addr | input | 24 | Byte address of the request |
| req_be | input | 2 | Byte enables: bit 1 odd byte, bit 0 even byte |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | Request comes from the DMA engine |
| req_rom | input | 1 | Request targets ROM |
| ref_req | input | 1 | Refresh request |
| ma | output | 10 | Multiplexed memory address |
| ras_n | output | 8 | RAS strobes, or pseudo-static upper address bits |
| cash_n | output | 4 | High-byte CAS, or pseudo-static chip selects |
| casl_n | output | 4 | Low-byte CAS, or pseudo-static enables |
| mdir | output | 1 | Data direction, 1 = memory read |
| mref_n | output | 1 | Refresh indicator, active low |
| done | output | 1 | Pulses in the last clock of an access |

## Verification
A refresh request and a memory request can arrive in the same idle clock. That clock decides which of the two cycles owns the RAS lines. The bench raises `ref_req` and `req_valid` on one falling edge. It then expects, clock by clock, a full refresh pattern (all RAS low, `mref_n` low, no CAS) followed at once by the access, with its row phase, column phase and single `done`. Any overlap or gap between the two shows up as a strobe mismatch in one specific clock.

// File: rtl/memseq_pkg.sv
`timescale 1ns/1ps
// Package: shared state and request types for the memory cycle sequencer.
// Assumes a 24-bit byte address and a 10-bit multiplexed memory address.
package memseq_pkg;
    localparam int ADDR_W = 24;
    localparam int MA_W   = 10;
    localparam int BANKS  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2,
        ST_REF  = 2'd3
    } seq_st_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        be;
        logic              wr;
        logic              dma;
        logic              rom;
    } mem_req_t;
endpackage

// File: rtl/memseq_timer.sv
`timescale 1ns/1ps
// Module: cycle timer. Sequences idle, row phase, column phase and refresh.
// Assumes req_valid is held until done. Refresh exists only in DRAM mode.
// A refresh wins over a request seen in the same idle clock.
module memseq_timer
    import memseq_pkg::*;
#(
    parameter int RAS_CLKS = 4,
    parameter int COL_DLY  = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    dram_mode,
    input  logic    req_valid,
    input  logic    ref_req,
    output seq_st_t st,
    output logic    load,
    output logic    done
);
    localparam int CNT_W = $clog2(RAS_CLKS + 1);
    localparam logic [CNT_W-1:0] ROW_END = CNT_W'(COL_DLY - 1);
    localparam logic [CNT_W-1:0] COL_END = CNT_W'(RAS_CLKS - COL_DLY - 1);
    localparam logic [CNT_W-1:0] REF_END = CNT_W'(RAS_CLKS - 1);

    logic [CNT_W-1:0] cnt;
    logic             ref_pend;
    logic             ref_need;
    logic             start_ref;
    seq_st_t          st_nx;
    logic             cnt_clr;

    assign ref_need = dram_mode & (ref_req | ref_pend);

    // Next-state and load decision for the sequencer.
    always_comb begin
        st_nx   = st;
        load    = 1'b0;
        cnt_clr = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (ref_need) begin
                    st_nx = ST_REF; cnt_clr = 1'b1;
                end else if (req_valid) begin
                    st_nx = ST_ROW; cnt_clr = 1'b1; load = 1'b1;
                end
            end
            ST_ROW: if (cnt == ROW_END) begin
                st_nx = ST_COL; cnt_clr = 1'b1;
            end
            ST_COL: if (cnt == COL_END) begin
                st_nx = ST_IDLE; cnt_clr = 1'b1;
            end
            ST_REF: if (cnt == REF_END) begin
                cnt_clr = 1'b1;
                if (ref_need)       st_nx = ST_REF;
                else if (req_valid) begin
                    st_nx = ST_ROW; load = 1'b1;
                end else            st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    assign start_ref = (st_nx == ST_REF) && (st != ST_REF || cnt == REF_END);
    assign done      = (st == ST_COL) && (cnt == COL_END);

    // State and phase counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_clr ? '0 : cnt + 1'b1;
        end
    end

    // Holds a refresh request that arrives while a cycle is running.
    always_ff @(posedge clk) begin
        if (!rst_n || !dram_mode) ref_pend <= 1'b0;
        else if (start_ref)       ref_pend <= 1'b0;
        else if (ref_req)         ref_pend <= 1'b1;
    end
endmodule

// File: rtl/memseq_addr.sv
`timescale 1ns/1ps
// Module: address decode. Derives DRAM bank/row/column and pseudo-static
// address fields from the latched request. Purely combinational.
module memseq_addr
    import memseq_pkg::*;
(
    input  mem_req_t        q,
    input  logic            big_dev,
    output logic [1:0]      bank,
    output logic [MA_W-1:0] row,
    output logic [MA_W-1:0] col,
    output logic [MA_W-1:0] sr_ma,
    output logic [3:0]      sr_lo,
    output logic [3:0]      sr_ext,
    output logic            sr_base,
    output logic [1:0]      sr_sel
);
    // DRAM split by device size.
    always_comb begin
        if (big_dev) begin
            bank = q.addr[22:21];
            row  = q.addr[20:11];
            col  = q.addr[10:1];
        end else begin
            bank = q.addr[20:19];
            row  = {1'b0, q.addr[18:10]};
            col  = {1'b0, q.addr[9:1]};
        end
    end

    // Pseudo-static fields; code 1111 means no extended device.
    always_comb begin
        sr_ma   = q.addr[11:2];
        sr_lo   = q.addr[15:12];
        sr_base = (q.addr[23:20] == 4'd0);
        sr_ext  = sr_base ? 4'hF : q.addr[23:20] - 4'd1;
        sr_sel  = {q.addr[19], q.addr[1]};
    end
endmodule

// File: rtl/memseq_pins.sv
`timescale 1ns/1ps
// Module: pin mux. Builds DRAM strobes or pseudo-static enables on the
// shared pins from sequencer state and decoded address. Combinational.
module memseq_pins
    import memseq_pkg::*;
(
    input  seq_st_t         st,
    input  mem_req_t        q,
    input  logic            dram_mode,
    input  logic [1:0]      bank,
    input  logic [MA_W-1:0] row,
    input  logic [MA_W-1:0] col,
    input  logic [MA_W-1:0] sr_ma,
    input  logic [3:0]      sr_lo,
    input  logic [3:0]      sr_ext,
    input  logic            sr_base,
    input  logic [1:0]      sr_sel,
    output logic [MA_W-1:0] ma,
    output logic [7:0]      ras_n,
    output logic [3:0]      cash_n,
    output logic [3:0]      casl_n,
    output logic            mdir,
    output logic            mref_n
);
    logic       busy;
    logic       strobe;
    logic       in_col;
    logic [7:0] d_ras;
    logic [3:0] d_cash, d_casl, s_cs;

    assign busy   = (st == ST_ROW) || (st == ST_COL);
    assign strobe = busy && !q.rom;
    assign in_col = (st == ST_COL) && !q.rom;

    // Per-bank DRAM RAS pairs and byte-lane CAS lines.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign d_ras[2*b+1:2*b] = (st == ST_REF || (strobe && bank == b)) ? 2'b00 : 2'b11;
        assign d_cash[b] = !(in_col && bank == b && q.be[1]);
        assign d_casl[b] = !(in_col && bank == b && q.be[0]);
        assign s_cs[b]   = !(strobe && sr_base && sr_sel == b);
    end

    // Selects the pin function by memory mode.
    always_comb begin
        mdir = busy && (!q.wr || (q.rom && !q.dma));
        if (dram_mode) begin
            ma     = (st == ST_COL) ? col : row;
            ras_n  = d_ras;
            cash_n = d_cash;
            casl_n = d_casl;
            mref_n = (st != ST_REF);
        end else begin
            ma     = sr_ma;
            ras_n  = {sr_ext, sr_lo};
            cash_n = s_cs;
            casl_n = {!(strobe && !q.wr), !strobe,
                      !(strobe && q.wr && q.be[1]), !(strobe && q.wr && q.be[0])};
            mref_n = 1'b0;
        end
    end
endmodule

// File: rtl/memseq_top.sv
`timescale 1ns/1ps
// Module: memory cycle sequencer top. Latches a request on acceptance and
// drives DRAM or pseudo-static RAM strobes. Assumes dram_mode and big_dev
// change only while idle, and that requests are held until done.
module memseq_top
    import memseq_pkg::*;
#(
    parameter int RAS_CLKS = 4,
    parameter int COL_DLY  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dram_mode,
    input  logic        big_dev,
    input  logic        req_valid,
    input  logic [23:0] req_addr,
    input  logic [1:0]  req_be,
    input  logic        req_wr,
    input  logic        req_dma,
    input  logic        req_rom,
    input  logic        ref_req,
    output logic [9:0]  ma,
    output logic [7:0]  ras_n,
    output logic [3:0]  cash_n,
    output logic [3:0]  casl_n,
    output logic        mdir,
    output logic        mref_n,
    output logic        done
);
    seq_st_t         st;
    logic            load;
    mem_req_t        q;
    logic [1:0]      bank, sr_sel;
    logic [MA_W-1:0] row, col, sr_ma;
    logic [3:0]      sr_lo, sr_ext;
    logic            sr_base;

    // Captures the request when the sequencer accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= '{addr: req_addr, be: req_be, wr: req_wr,
                              dma: req_dma, rom: req_rom};
    end

    memseq_timer #(.RAS_CLKS(RAS_CLKS), .COL_DLY(COL_DLY)) u_timer (
        .clk(clk), .rst_n(rst_n), .dram_mode(dram_mode), .req_valid(req_valid),
        .ref_req(ref_req), .st(st), .load(load), .done(done)
    );

    memseq_addr u_addr (
        .q(q), .big_dev(big_dev), .bank(bank), .row(row), .col(col),
        .sr_ma(sr_ma), .sr_lo(sr_lo), .sr_ext(sr_ext), .sr_base(sr_base),
        .sr_sel(sr_sel)
    );

    memseq_pins u_pins (
        .st(st), .q(q), .dram_mode(dram_mode), .bank(bank), .row(row),
        .col(col), .sr_ma(sr_ma), .sr_lo(sr_lo), .sr_ext(sr_ext),
        .sr_base(sr_base), .sr_sel(sr_sel), .ma(ma), .ras_n(ras_n),
        .cash_n(cash_n), .casl_n(casl_n), .mdir(mdir), .mref_n(mref_n)
    );
endmodule

// File: rtl/memseq_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for the memory cycle sequencer, bound to the top.
module memseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dram_mode,
    input logic [7:0] ras_n,
    input logic [3:0] cash_n,
    input logic [3:0] casl_n,
    input logic       mref_n,
    input logic       done
);
    // R3: outside refresh, any RAS activity is exactly one bank pair.
    p_ras_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_mode && mref_n && ras_n != 8'hFF) |->
        ((~ras_n) inside {8'h03, 8'h0C, 8'h30, 8'hC0}));

    // R2: CAS only while RAS is low, and RAS was already low a clock earlier.
    p_cas_after_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_mode && (cash_n != 4'hF || casl_n != 4'hF)) |->
        (ras_n != 8'hFF && $past(ras_n) != 8'hFF));

    // R6: refresh drives every RAS and no CAS.
    p_ref_nocas_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_mode && !mref_n) |->
        (ras_n == 8'h00 && cash_n == 4'hF && casl_n == 4'hF));

    // R11: pseudo-static mode keeps the refresh indicator low.
    p_sram_mref_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_mode |-> !mref_n);

    // R9: at most one pseudo-static chip select at a time.
    p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_mode |-> $onehot0(~cash_n));

    // R2: done is a single-clock pulse.
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind memseq_top memseq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dram_mode(dram_mode), .ras_n(ras_n),
    .cash_n(cash_n), .casl_n(casl_n), .mref_n(mref_n), .done(done)
);

// File: tb/memseq_top_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected per-clock pin snapshots,
// a monitor pops one per falling edge and compares.
module memseq_top_test;
    localparam int RAS_CLKS = 4;
    localparam int COL_DLY  = 1;

    typedef struct packed {
        logic [9:0] ma;
        logic [7:0] ras;
        logic [3:0] cash;
        logic [3:0] casl;
        logic       mdir;
        logic       mref;
        logic       done;
    } snap_t;

    logic clk = 1'b0, rst_n = 1'b0, dram_mode = 1'b1, big_dev = 1'b1;
    logic req_valid = 1'b0, req_wr = 1'b0, req_dma = 1'b0, req_rom = 1'b0, ref_req = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [9:0]  ma;
    logic [7:0]  ras_n;
    logic [3:0]  cash_n, casl_n;
    logic        mdir, mref_n, done;

    int n_chk = 0, n_fail = 0;
    snap_t exp_q[$];
    string tag_q[$];
    logic [23:0] l_addr = '0;
    logic [1:0]  l_be = '0;
    logic        l_wr = 1'b0, l_dma = 1'b0, l_rom = 1'b0;

    always #10 clk = ~clk;

    memseq_top #(.RAS_CLKS(RAS_CLKS), .COL_DLY(COL_DLY)) uut (
        .clk(clk), .rst_n(rst_n), .dram_mode(dram_mode), .big_dev(big_dev),
        .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
        .req_wr(req_wr), .req_dma(req_dma), .req_rom(req_rom), .ref_req(ref_req),
        .ma(ma), .ras_n(ras_n), .cash_n(cash_n), .casl_n(casl_n),
        .mdir(mdir), .mref_n(mref_n), .done(done)
    );

    // Expected pins: ph 0 row phase, 1 column phase, 2 refresh, 3 idle.
    function automatic snap_t model(int ph, logic [23:0] a, logic [1:0] be,
                                    logic wr, logic dma, logic rom);
        snap_t s;
        int bk;
        logic [9:0] row, col;
        logic base;
        logic act;
        act = (ph == 0 || ph == 1);
        s = '{ma: '0, ras: 8'hFF, cash: 4'hF, casl: 4'hF, mdir: 1'b0, mref: 1'b1, done: 1'b0};
        if (act) s.mdir = !wr || (rom && !dma);                 // R12
        if (dram_mode) begin
            bk  = big_dev ? int'(a[22:21]) : int'(a[20:19]);    // R3 R4
            row = big_dev ? a[20:11] : {1'b0, a[18:10]};
            col = big_dev ? a[10:1]  : {1'b0, a[9:1]};
            s.ma = (ph == 1) ? col : row;
            if (act && !rom) s.ras[2*bk +: 2] = 2'b00;
            if (ph == 1 && !rom) begin                          // R5
                s.cash[bk] = !be[1];
                s.casl[bk] = !be[0];
            end
            if (ph == 2) begin                                  // R6
                s.ras = 8'h00;
                s.mref = 1'b0;
            end
        end else begin
            base   = (a[23:20] == 4'd0);                        // R8
            s.ma   = a[11:2];
            s.ras  = {base ? 4'hF : a[23:20] - 4'd1, a[15:12]};
            s.mref = 1'b0;                                      // R11
            if (act && !rom) begin                              // R10 R9
                s.casl = {wr, 1'b0, !(wr && be[1]), !(wr && be[0])};
                if (base) s.cash[{a[19], a[1]}] = 1'b0;
            end
        end
        return s;
    endfunction

    task automatic compare(snap_t e, string tag);
        snap_t a;
        a = '{ma: ma, ras: ras_n, cash: cash_n, casl: casl_n, mdir: mdir,
              mref: mref_n, done: done};
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual ma=%h ras=%h cash=%h casl=%h mdir=%b mref=%b done=%b expected ma=%h ras=%h cash=%h casl=%h mdir=%b mref=%b done=%b",
                     tag, a.ma, a.ras, a.cash, a.casl, a.mdir, a.mref, a.done,
                     e.ma, e.ras, e.cash, e.casl, e.mdir, e.mref, e.done);
        end
    endtask

    // Monitor: one expected snapshot per falling edge while the queue holds any.
    always @(negedge clk) begin
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic push(snap_t s, string tag);
        exp_q.push_back(s);
        tag_q.push_back(tag);
    endtask

    task automatic wait_empty();
        do begin
            @(negedge clk); #1;
        end while (exp_q.size() != 0);
    endtask

    task automatic push_idle(string tag);
        @(posedge clk); #1;
        push(model(3, l_addr, l_be, l_wr, l_dma, l_rom), tag);
        wait_empty();
    endtask

    // Driver: one access, optionally colliding with a refresh request.
    task automatic run_req(logic [23:0] a, logic [1:0] be, logic wr, logic dma,
                           logic rom, logic with_ref, string tag);
        snap_t s;
        @(negedge clk);
        req_addr = a; req_be = be; req_wr = wr; req_dma = dma; req_rom = rom;
        req_valid = 1'b1;
        ref_req = with_ref;
        @(posedge clk); #1;
        if (with_ref)
            for (int i = 0; i < RAS_CLKS; i++)
                push(model(2, l_addr, l_be, l_wr, l_dma, l_rom), {tag, " R7 refresh first"});
        l_addr = a; l_be = be; l_wr = wr; l_dma = dma; l_rom = rom;
        for (int i = 0; i < RAS_CLKS; i++) begin
            s = model(i < COL_DLY ? 0 : 1, a, be, wr, dma, rom);
            s.done = (i == RAS_CLKS - 1);
            push(s, tag);
        end
        @(negedge clk); #1;
        ref_req = 1'b0;
        wait_empty();
        req_valid = 1'b0;
        push_idle({tag, " R2 idle after done"});
    endtask

    // Driver: refresh request alone (ignored in pseudo-static mode).
    task automatic run_ref(string tag);
        @(negedge clk);
        ref_req = 1'b1;
        @(posedge clk); #1;
        for (int i = 0; i < RAS_CLKS; i++)
            push(model(dram_mode ? 2 : 3, l_addr, l_be, l_wr, l_dma, l_rom), tag);
        @(negedge clk); #1;
        ref_req = 1'b0;
        wait_empty();
        push_idle({tag, " idle after"});
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(model(3, '0, '0, 1'b0, 1'b0, 1'b0), "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(model(3, '0, '0, 1'b0, 1'b0, 1'b0), "R1 after reset");

        // DRAM, 1M devices: banks, lanes, read/write.
        run_req(24'h00_1236, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R3 R12 bank0 read");
        run_req(24'h25_A7F2, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R3 R5 bank1 even write");
        run_req(24'h5C_3C0A, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R3 R5 bank2 odd write");
        run_req(24'h7F_FFFE, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R3 R12 bank3 DMA write");
        run_req(24'h61_0040, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, "R12 DMA read");
        run_req(24'h0F_0000, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, "R13 R12 ROM access");
        run_req(24'h0F_0002, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, "R13 R12 DMA ROM write");

        // DRAM, 256K devices.
        big_dev = 1'b0;
        push_idle("R4 mode change idle");
        run_req(24'h1F_FFFE, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R4 bank3 top");
        run_req(24'h0A_5554, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R5 bank1 write");
        big_dev = 1'b1;

        // Refresh alone and colliding with a request.
        run_ref("R6 refresh");
        run_req(24'h43_2100, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, "R7 collision access");
        run_req(24'h12_0006, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, "R7 R6 collision write");

        // Pseudo-static RAM mode.
        dram_mode = 1'b0;
        push_idle("R8 R11 mode change idle");
        run_req(24'h00_0000, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R8 R9 R10 low even read");
        run_req(24'h0A_BCD2, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R9 R10 high odd even-byte write");
        run_req(24'h07_3006, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R9 R10 low odd odd-byte write");
        run_req(24'h08_1000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R9 R10 high even word write");
        run_req(24'h35_F00C, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R8 R9 extended region read");
        run_req(24'hF1_2344, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R8 top region DMA write");
        run_req(24'h04_0000, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, "R13 pseudo-static ROM");
        run_ref("R11 refresh ignored");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule